// File: doc/BRIEF.md
# Main Clock Failure Supervisor

This block watches a main clock from the domain of a free-running backup oscillator. A toggle flop in the main-clock domain is carried into the backup domain through a synchronizer. A counter there measures how long it has been since the last toggle arrived. When the main clock goes quiet for too long, the block reports the condition, latches a sticky event flag, forces CPU clock selection over to the on-chip backup oscillator, and issues a one-cycle interrupt request.

Software controls and observes the block through one byte-wide register with a plain write strobe. Two external inputs qualify writes. One opens the register for writing at all. The other freezes the supervision-enable bit so that no write can switch supervision off. The failover select does not clear by itself when the main clock comes back, so software decides when to return to the main source.

Top module: `osc_watch`

## Requirements
- R1: After reset the register reads 0x00. Bits 7..4 always read 0, and writing them has no effect.
- R2: Bit 3 is a read-only live status bit: 1 when no main-clock edge has reached the backup domain for 16 backup cycles, and 0 again a few cycles after the main clock resumes. Writes to bit 3 are ignored.
- R3: While bit 0 (supervision enable) is 0, a main-clock stop leaves bit 1, bit 2 and the interrupt output unchanged.
- R4: With bit 0 at 1, a detected stop sets bit 2 (event flag) and bit 1 (select backup oscillator, also driven on `cpu_sel_backup`). Bit 1 stays 1 after the main clock resumes, until software writes it to 0.
- R5: Writing 1 to bit 2 has no effect, and writing 0 clears it. If it is cleared while the main clock is still stopped, it stays 0 until a new stop is detected after the clock has run again.
- R6: A write changes nothing unless `prot_open` is 1 during the write cycle.
- R7: While `clk_lock` is 1, a write leaves bit 0 unchanged, and bits 1 and 2 still follow the write rules.
- R8: While bits 0 and 2 are both 1, a write of 0 to bit 1 is ignored.
- R9: `stop_irq` is a single backup-cycle pulse. It is high in the first cycle in which bit 2 reads 1 after a detected stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bk_clk | input | 1 | Backup oscillator clock; all register logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Main clock under supervision |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_open | input | 1 | 1 allows register writes |
| clk_lock | input | 1 | 1 freezes the enable bit against writes |
| rd_data | output | 8 | Current register value |
| cpu_sel_backup | output | 1 | 1 selects the backup oscillator as CPU clock |
| stop_irq | output | 1 | One-cycle stop interrupt request |

## Verification
The bound checker enforces these rules on every cycle:
- the reserved bits read as zero;
- the interrupt is a single cycle wide and coincides with the event flag and the select bit being set;
- the flag never rises without an interrupt;
- the enable bit holds under lock or protection;
- the select output mirrors bit 1.

Only the bench scenarios can show the following:
- the stop threshold against a main clock that is actually halted and restarted;
- that the select bit survives recovery;
- that a clear during an ongoing stop does not re-arm the flag;
- that bit 1 is refused a return to a dead clock.

The bench also compares the write semantics against a model under random protect and lock patterns.

// File: rtl/osc_watch_pkg.sv
package osc_watch_pkg;
  localparam int REG_W   = 8;
  localparam int B_EN    = 0;
  localparam int B_SEL   = 1;
  localparam int B_FLAG  = 2;
  localparam int B_LIVE  = 3;
endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/osc_edge_sync.sv
// Carries main-clock activity into the backup domain as a one-cycle "seen" strobe.
module osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic bk_clk,
  input  logic rst_n,
  input  logic rst_sync_n,
  output logic seen
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic              tgl_q;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  always_comb chain_d = {chain_q[CHAIN_W-2:0], tgl_q};

  always_ff @(posedge bk_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) chain_q <= '0;
    else             chain_q <= chain_d;
  end

  assign seen = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
endmodule

// File: rtl/osc_stop_timer.sv
// Counts backup cycles without a main-clock strobe; flags a stop at the limit.
module osc_stop_timer #(
  parameter int STOP_LIMIT = 16
) (
  input  logic bk_clk,
  input  logic rst_sync_n,
  input  logic seen,
  output logic stopped,
  output logic stop_evt
);
  localparam int CNT_W = $clog2(STOP_LIMIT);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STOP_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stopped_q, stopped_d;
  logic             cnt_en;

  assign cnt_en   = (cnt_q != CNT_TOP);
  assign stop_evt = !seen && !stopped_q && !cnt_en;

  always_comb begin
    cnt_d     = cnt_q;
    stopped_d = stopped_q;
    if (seen) begin
      cnt_d     = '0;
      stopped_d = 1'b0;
    end else begin
      if (cnt_en)   cnt_d     = cnt_q + 1'b1;
      if (stop_evt) stopped_d = 1'b1;
    end
  end

  always_ff @(posedge bk_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q     <= '0;
      stopped_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      stopped_q <= stopped_d;
    end
  end

  assign stopped = stopped_q;
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_watch_pkg::*;
(
  input  logic             bk_clk,
  input  logic             rst_sync_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_bits,
  input  logic             prot_open,
  input  logic             clk_lock,
  input  logic             stopped,
  input  logic             stop_evt,
  output logic [REG_W-1:0] reg_val,
  output logic             irq
);
  logic en_q, en_d, sel_q, sel_d, flag_q, flag_d, irq_q, irq_d;
  logic wr_ok;

  assign wr_ok = wr_en && prot_open;

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    flag_d = flag_q;
    irq_d  = 1'b0;
    if (wr_ok) begin
      if (!clk_lock) en_d = wr_bits[B_EN];
      // refuse a return to the main clock while a stop is still flagged
      if (wr_bits[B_SEL] || !(en_q && flag_q)) sel_d = wr_bits[B_SEL];
      if (!wr_bits[B_FLAG]) flag_d = 1'b0;
    end
    if (stop_evt && en_q) begin
      sel_d  = 1'b1;
      flag_d = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge bk_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    reg_val         = '0;
    reg_val[B_EN]   = en_q;
    reg_val[B_SEL]  = sel_q;
    reg_val[B_FLAG] = flag_q;
    reg_val[B_LIVE] = stopped;
  end

  assign irq = irq_q;
endmodule

// File: rtl/osc_watch.sv
module osc_watch
  import osc_watch_pkg::*;
#(
  parameter int STOP_LIMIT  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             bk_clk,
  input  logic             rst_n,
  input  logic             mclk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             prot_open,
  input  logic             clk_lock,
  output logic [REG_W-1:0] rd_data,
  output logic             cpu_sel_backup,
  output logic             stop_irq
);
  logic rst_sync_n, seen, stopped, stop_evt;
  logic [REG_W-4:0] unused_wr_bits;

  assign unused_wr_bits = wr_data[REG_W-1:3];

  osc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(bk_clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .mclk(mclk), .bk_clk(bk_clk), .rst_n(rst_n),
    .rst_sync_n(rst_sync_n), .seen(seen));

  osc_stop_timer #(.STOP_LIMIT(STOP_LIMIT)) u_timer (
    .bk_clk(bk_clk), .rst_sync_n(rst_sync_n), .seen(seen),
    .stopped(stopped), .stop_evt(stop_evt));

  osc_ctrl_reg u_reg (
    .bk_clk(bk_clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en),
    .wr_bits(wr_data[2:0]), .prot_open(prot_open), .clk_lock(clk_lock),
    .stopped(stopped), .stop_evt(stop_evt), .reg_val(rd_data),
    .irq(stop_irq));

  assign cpu_sel_backup = rd_data[B_SEL];
endmodule

// File: rtl/osc_watch_chk.sv
module osc_watch_chk (
  input logic       bk_clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       cpu_sel_backup,
  input logic       stop_irq,
  input logic       prot_open,
  input logic       clk_lock
);
  p_rsvd_zero_r1: assert property (@(posedge bk_clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);

  p_sel_port_r4: assert property (@(posedge bk_clk) disable iff (!rst_n)
    cpu_sel_backup == rd_data[1]);

  p_flag_needs_irq_r5: assert property (@(posedge bk_clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> stop_irq);

  p_hold_unprot_r6: assert property (@(posedge bk_clk) disable iff (!rst_n)
    !prot_open |=> $stable(rd_data[0]));

  p_lock_en_r7: assert property (@(posedge bk_clk) disable iff (!rst_n)
    clk_lock |=> $stable(rd_data[0]));

  p_irq_flags_r9: assert property (@(posedge bk_clk) disable iff (!rst_n)
    stop_irq |-> (rd_data[2] && rd_data[1] && rd_data[0]));

  p_irq_pulse_r9: assert property (@(posedge bk_clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);
endmodule

bind osc_watch osc_watch_chk u_chk (
  .bk_clk(bk_clk), .rst_n(rst_n), .rd_data(rd_data),
  .cpu_sel_backup(cpu_sel_backup), .stop_irq(stop_irq),
  .prot_open(prot_open), .clk_lock(clk_lock));

// File: tb/osc_watch_bench.sv
`timescale 1ns/1ps
module osc_watch_bench;
  logic       bk_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mclk = 1'b0;
  logic       mclk_run = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       prot_open = 1'b0;
  logic       clk_lock = 1'b0;
  logic [7:0] rd_data;
  logic       cpu_sel_backup, stop_irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int irq_bad = 0;
  logic irq_prev = 1'b0;

  osc_watch u_osc_watch (
    .bk_clk(bk_clk), .rst_n(rst_n), .mclk(mclk), .wr_en(wr_en),
    .wr_data(wr_data), .prot_open(prot_open), .clk_lock(clk_lock),
    .rd_data(rd_data), .cpu_sel_backup(cpu_sel_backup), .stop_irq(stop_irq));

  always #4 bk_clk = ~bk_clk;
  always begin
    #10;
    if (mclk_run) mclk = ~mclk;
  end

  // R9 monitor: pulse width and coincidence with the flag
  always @(negedge bk_clk) begin
    if (rst_n) begin
      if (stop_irq) begin
        irq_cnt++;
        if (irq_prev || !rd_data[2]) irq_bad++;
      end
      irq_prev = stop_irq;
    end
  end

  function automatic logic [2:0] model_next(logic [2:0] cur, logic [7:0] wd,
                                            logic prot, logic lock);
    logic [2:0] r = cur;
    if (prot) begin
      if (!lock) r[0] = wd[0];
      if (wd[1] || !(cur[0] && cur[2])) r[1] = wd[1];
      if (!wd[2]) r[2] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] wd, logic prot, logic lock);
    @(negedge bk_clk);
    wr_en = 1'b1; wr_data = wd; prot_open = prot; clk_lock = lock;
    @(negedge bk_clk);
    wr_en = 1'b0; prot_open = 1'b0; clk_lock = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge bk_clk);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] mdl;
    void'($urandom(32'd4242));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 reset", rd_data, 8'h00);
    check("R1 irq reset", stop_irq, 1'b0);

    // random writes, main clock running
    mdl = 3'b000;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] wd = 8'($urandom);
      logic prot = ($urandom % 4) != 0;
      logic lock = ($urandom % 3) == 0;
      do_write(wd, prot, lock);
      mdl = model_next(mdl, wd, prot, lock);
      check("R1 R6 R7 random", rd_data, {5'b0, mdl});
    end

    // R3: disabled, stop has no effect
    do_write(8'h00, 1'b1, 1'b0);
    mclk_run = 1'b0;
    wait_cyc(40);
    check("R2 live stop", rd_data[3], 1'b1);
    check("R3 disabled", rd_data, 8'h08);
    check("R3 no irq", irq_cnt, 0);
    do_write(8'hF8, 1'b1, 1'b0);
    check("R2 live not writable", rd_data, 8'h08);
    mclk_run = 1'b1;
    wait_cyc(10);
    check("R2 live resume", rd_data, 8'h00);

    // R4 / R9: enabled stop
    do_write(8'h01, 1'b1, 1'b0);
    mclk_run = 1'b0;
    wait_cyc(40);
    check("R4 failover", rd_data, 8'h0F);
    check("R4 select port", cpu_sel_backup, 1'b1);
    check("R9 one irq", irq_cnt, 1);

    // R8: attempt to go back to the dead clock
    do_write(8'h05, 1'b1, 1'b0);
    check("R8 sel held", rd_data, 8'h0F);

    // R5: clear flag during stop; must not re-arm
    do_write(8'h03, 1'b1, 1'b0);
    check("R5 clear", rd_data, 8'h0B);
    wait_cyc(30);
    check("R5 no rearm", rd_data, 8'h0B);
    check("R5 no irq", irq_cnt, 1);

    mclk_run = 1'b1;
    wait_cyc(10);
    check("R4 sel survives resume", rd_data, 8'h03);
    do_write(8'h01, 1'b1, 1'b0);
    check("R4 sw returns sel", rd_data, 8'h01);
    do_write(8'h05, 1'b1, 1'b0);
    check("R5 write1 no effect", rd_data, 8'h01);

    // new stop event re-arms
    mclk_run = 1'b0;
    wait_cyc(40);
    check("R5 new event", rd_data, 8'h0F);
    check("R9 second irq", irq_cnt, 2);

    // R6: protected write ignored
    do_write(8'h00, 1'b0, 1'b0);
    check("R6 protected", rd_data, 8'h0F);
    // R7: lock holds enable, flag clear still applies, R8 keeps sel
    do_write(8'h00, 1'b1, 1'b1);
    check("R7 lock", rd_data, 8'h0B);
    mclk_run = 1'b1;
    wait_cyc(10);
    do_write(8'h00, 1'b1, 1'b0);
    check("R7 unlocked write", rd_data, 8'h00);

    check("R9 pulse shape", irq_bad, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule